// File: doc/BRIEF.md
# Dual Alarm Comparator Unit

This block holds two independent alarm channels and compares each against the live BCD time supplied by a separate timekeeping block. The weekly channel (W) stores a minute, an hour and a seven-bit mask of weekdays, so a single alarm can fire on any chosen set of days. The daily channel (D) stores only a minute and an hour and fires every day. A comparison is made only in the cycle the time source marks as a minute rollover, and only when the seconds read 00.

On a match, an enabled channel sets a sticky flag and pulls its own active-low interrupt output. The output models an open-drain pin: low means asserted, high means released. Software polls the flags in a status register and clears them by writing 0. Clearing a channel's enable bit also clears its flag. An oscillator-halt strobe clears both enables and both flags, which releases both outputs. The stored alarm times are left intact.

The register port is a plain single-cycle strobe with no back-pressure. A write is taken in the cycle `reg_wr` is high, and the effect is visible after the next rising edge. A read is combinational from `reg_addr`. The time inputs are plain levels, qualified by `min_tick`.

Top module: `dual_alarm_unit`

## Requirements
- R1: After reset every register address reads 0x00, and both `irq_w_n` and `irq_d_n` are high.
- R2: The register map is as follows. Address 0 is W minute (7 bits), 1 is W hour (6 bits), 2 is W weekday mask (bit n = weekday code n, n = 0..6), 3 is D minute (7 bits), 4 is D hour (6 bits), 5 is control (bit 1 = W enable, bit 0 = D enable) and 6 is status (bit 1 = W flag, bit 0 = D flag). Bits outside a field read 0, and address 7 reads 0.
- R3: When `min_tick` is high, `now_sec` is 0x00, `now_min` equals the W minute, `now_hour` equals the W hour and the mask bit for `now_wday` is set, an enabled W channel sets status bit 1 and drives `irq_w_n` low after that edge.
- R4: The W channel does not match when the mask bit for the current weekday is clear, or when `now_wday` is 7.
- R5: The D channel matches on minute and hour alone, whatever `now_wday` holds. It sets status bit 0 and drives `irq_d_n` low.
- R6: No match happens while `min_tick` is low, or while `now_sec` is not 0x00.
- R7: A channel whose enable bit is 0 never sets its flag, and its output stays high.
- R8: A set flag, and its low output, stay set through later cycles and later matches until they are cleared.
- R9: Writing 0 to a status flag bit clears that flag and releases its output. Writing 1 to a flag bit has no effect.
- R10: Writing 0 to a channel's enable bit clears that channel's flag and releases its output in the same edge.
- R11: A high `osc_halt` clears both enables and both flags and releases both outputs. Stored alarm minutes, hours and mask are kept.
- R12: If a match and a write of 0 to the same flag occur in one cycle, the flag ends up set.
- R13: Hours are compared as the raw 6-bit code, including bit 5 (PM in 12-hour form). For example, 0x32 and 0x12 do not match each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_halt | input | 1 | Oscillator-halt status reset strobe |
| min_tick | input | 1 | High for one cycle when the minute counter increments |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hour code, BCD (bit 5 = PM in 12-hour form) |
| now_wday | input | 3 | Current weekday code, 0..6 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq_w_n | output | 1 | Weekly-channel interrupt, active low |
| irq_d_n | output | 1 | Daily-channel interrupt, active low |

## Verification
The embedded assertions check the following on every cycle:
- A flag is never set while its enable is clear.
- A flag rises only after a minute-tick cycle.
- A flag holds unless a clear, an enable drop or a halt occurs.
- A clear write with no coincident match, or a halt, leaves the output released.
- Padding bits read back as zero.

The bench scenarios are needed for the rest:
- That the compared values are the right ones: minute, the raw hour code with its PM bit, and the weekday mask bit, including the out-of-range weekday code 7.
- That a coincident match beats a clear write.
- That writing 1 to a flag does nothing.
- That stored alarm fields survive a halt.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int NUM_CH = 2;
  localparam int W_IDX  = 1;
  localparam int D_IDX  = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_WMIN  = 3'd0,
    A_WHOUR = 3'd1,
    A_WMASK = 3'd2,
    A_DMIN  = 3'd3,
    A_DHOUR = 3'd4,
    A_CTRL  = 3'd5,
    A_STAT  = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [MIN_W-1:0]  mins;
    logic [HOUR_W-1:0] hours;
  } alarm_time_t;
endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
#(
  parameter bit USE_WDAY = 1'b1,
  parameter int DAYS     = 7,
  parameter int WDAY_W   = 3
) (
  input  logic              min_tick,
  input  logic [7:0]        now_sec,
  input  logic [7:0]        now_min,
  input  logic [7:0]        now_hour,
  input  logic [WDAY_W-1:0] now_wday,
  input  alarm_time_t       target,
  input  logic [DAYS-1:0]   day_mask,
  output logic              hit
);
  logic time_eq;
  logic day_ok;

  assign time_eq = (now_sec == 8'h00)
                && (now_min  == {{(8-MIN_W){1'b0}},  target.mins})
                && (now_hour == {{(8-HOUR_W){1'b0}}, target.hours});

  generate
    if (USE_WDAY) begin : g_wday
      always_comb begin
        day_ok = 1'b0;
        for (int i = 0; i < DAYS; i++) begin
          if (now_wday == WDAY_W'(i)) day_ok = day_mask[i];
        end
      end
    end else begin : g_daily
      logic unused_wday;
      assign unused_wday = ^{now_wday, day_mask};
      assign day_ok = 1'b1;
    end
  endgenerate

  assign hit = min_tick && time_eq && day_ok;
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
  import alarm_pkg::*;
#(
  parameter bit USE_WDAY = 1'b1,
  parameter int DAYS     = 7,
  parameter int WDAY_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              wr_min,
  input  logic              wr_hour,
  input  logic              wr_mask,
  input  logic [MIN_W-1:0]  min_data,
  input  logic [HOUR_W-1:0] hour_data,
  input  logic [DAYS-1:0]   mask_data,
  input  logic              en,
  input  logic              en_drop,
  input  logic              flag_clr,
  input  logic              min_tick,
  input  logic [7:0]        now_sec,
  input  logic [7:0]        now_min,
  input  logic [7:0]        now_hour,
  input  logic [WDAY_W-1:0] now_wday,
  output alarm_time_t       time_q,
  output logic [DAYS-1:0]   mask_q,
  output logic              flag_q,
  output logic              irq_n
);
  logic hit;
  logic set_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else begin
      if (wr_min)  time_q.mins  <= min_data;
      if (wr_hour) time_q.hours <= hour_data;
    end
  end

  generate
    if (USE_WDAY) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= mask_data;
      end
    end else begin : g_nomask
      logic unused_mask;
      assign unused_mask = ^{wr_mask, mask_data};
      assign mask_q = '0;
    end
  endgenerate

  alarm_cmp #(.USE_WDAY(USE_WDAY), .DAYS(DAYS), .WDAY_W(WDAY_W)) u_cmp (
    .min_tick (min_tick),
    .now_sec  (now_sec),
    .now_min  (now_min),
    .now_hour (now_hour),
    .now_wday (now_wday),
    .target   (time_q),
    .day_mask (mask_q),
    .hit      (hit)
  );

  assign set_flag = hit && en && !en_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag_q <= 1'b0;
    else if (halt)                flag_q <= 1'b0;
    else if (set_flag)            flag_q <= 1'b1;
    else if (en_drop || flag_clr) flag_q <= 1'b0;
  end

  assign irq_n = ~flag_q;

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> en); // R7
  AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(min_tick)); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr && !en_drop && !halt) |=> flag_q); // R8
  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit && !halt) |=> irq_n); // R9
  AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    en_drop |=> irq_n); // R10
  AST_HALT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (irq_n && !flag_q)); // R11
endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit
  import alarm_pkg::*;
#(
  parameter int DAYS = 7,
  localparam int WDAY_W = $clog2(DAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_halt,
  input  logic              min_tick,
  input  logic [7:0]        now_sec,
  input  logic [7:0]        now_min,
  input  logic [7:0]        now_hour,
  input  logic [WDAY_W-1:0] now_wday,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_w_n,
  output logic              irq_d_n
);
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] wr_min_v, wr_hour_v, wr_mask_v;
  logic [NUM_CH-1:0] en_drop_v, flag_clr_v, flag_v, irq_v;
  alarm_time_t       time_v [NUM_CH];
  logic [DAYS-1:0]   mask_v [NUM_CH];
  logic              wr_ctrl, wr_stat;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);

  assign wr_min_v[W_IDX]  = reg_wr && (reg_addr == A_WMIN);
  assign wr_min_v[D_IDX]  = reg_wr && (reg_addr == A_DMIN);
  assign wr_hour_v[W_IDX] = reg_wr && (reg_addr == A_WHOUR);
  assign wr_hour_v[D_IDX] = reg_wr && (reg_addr == A_DHOUR);
  assign wr_mask_v[W_IDX] = reg_wr && (reg_addr == A_WMASK);
  assign wr_mask_v[D_IDX] = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (osc_halt) en_q <= '0;
    else if (wr_ctrl)  en_q <= reg_wdata[NUM_CH-1:0];
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign en_drop_v[c]  = wr_ctrl && !reg_wdata[c];
      assign flag_clr_v[c] = wr_stat && !reg_wdata[c];

      alarm_channel #(
        .USE_WDAY (c == W_IDX),
        .DAYS     (DAYS),
        .WDAY_W   (WDAY_W)
      ) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (osc_halt),
        .wr_min    (wr_min_v[c]),
        .wr_hour   (wr_hour_v[c]),
        .wr_mask   (wr_mask_v[c]),
        .min_data  (reg_wdata[MIN_W-1:0]),
        .hour_data (reg_wdata[HOUR_W-1:0]),
        .mask_data (reg_wdata[DAYS-1:0]),
        .en        (en_q[c]),
        .en_drop   (en_drop_v[c]),
        .flag_clr  (flag_clr_v[c]),
        .min_tick  (min_tick),
        .now_sec   (now_sec),
        .now_min   (now_min),
        .now_hour  (now_hour),
        .now_wday  (now_wday),
        .time_q    (time_v[c]),
        .mask_q    (mask_v[c]),
        .flag_q    (flag_v[c]),
        .irq_n     (irq_v[c])
      );
    end
  endgenerate

  logic unused_dmask;
  assign unused_dmask = ^mask_v[D_IDX];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_WMIN:  reg_rdata = DATA_W'(time_v[W_IDX].mins);
      A_WHOUR: reg_rdata = DATA_W'(time_v[W_IDX].hours);
      A_WMASK: reg_rdata = DATA_W'(mask_v[W_IDX]);
      A_DMIN:  reg_rdata = DATA_W'(time_v[D_IDX].mins);
      A_DHOUR: reg_rdata = DATA_W'(time_v[D_IDX].hours);
      A_CTRL:  reg_rdata = DATA_W'(en_q);
      A_STAT:  reg_rdata = DATA_W'(flag_v);
      default: reg_rdata = '0;
    endcase
  end

  assign irq_w_n = irq_v[W_IDX];
  assign irq_d_n = irq_v[D_IDX];

  AST_MIN_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_WMIN || reg_addr == A_DMIN) |-> (reg_rdata[7] == 1'b0)); // R2
  AST_HALT_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    osc_halt |=> (en_q == '0)); // R11
endmodule

// File: tb/dual_alarm_unit_bench.sv
module dual_alarm_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_halt = 1'b0, min_tick = 1'b0, reg_wr = 1'b0;
  logic [7:0] now_sec = 8'h01, now_min = 8'h00, now_hour = 8'h00;
  logic [2:0] now_wday = 3'd0, reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic irq_w_n, irq_d_n;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model: index 1 = weekly, 0 = daily
  logic [1:0] m_en = 0, m_flag = 0;
  logic [6:0] m_min [2];
  logic [5:0] m_hour [2];
  logic [6:0] m_mask = 0;

  always #5 clk = ~clk;

  dual_alarm_unit u_dual_alarm_unit (
    .clk(clk), .rst_n(rst_n), .osc_halt(osc_halt), .min_tick(min_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_wday(now_wday),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_w_n(irq_w_n), .irq_d_n(irq_d_n));

  function automatic bit m_hit(int ch, logic tk, logic [7:0] s, logic [7:0] mi,
                               logic [7:0] h, logic [2:0] wd);
    bit ok;
    ok = tk && s == 8'h00 && mi == {1'b0, m_min[ch]} && h == {2'b00, m_hour[ch]};
    if (ch == 1) ok = ok && (wd < 3'd7) && m_mask[wd];
    return ok;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // one cycle of stimulus; model updated per requirements
  task automatic step(logic tk, logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                      logic [2:0] wd, logic wr, logic [2:0] a, logic [7:0] d, logic hl);
    bit drop, clr, st;
    @(negedge clk);
    min_tick = tk; now_sec = s; now_min = mi; now_hour = h; now_wday = wd;
    reg_wr = wr; reg_addr = a; reg_wdata = d; osc_halt = hl;
    for (int c = 0; c < 2; c++) begin
      drop = wr && a == 3'd5 && !d[c];
      clr  = wr && a == 3'd6 && !d[c];
      st   = m_hit(c, tk, s, mi, h, wd) && m_en[c] && !drop;
      if (hl) m_flag[c] = 0;
      else if (st) m_flag[c] = 1;
      else if (drop || clr) m_flag[c] = 0;
    end
    if (hl) m_en = 0;
    else if (wr && a == 3'd5) m_en = d[1:0];
    if (wr) begin
      case (a)
        3'd0: m_min[1] = d[6:0];
        3'd1: m_hour[1] = d[5:0];
        3'd2: m_mask = d[6:0];
        3'd3: m_min[0] = d[6:0];
        3'd4: m_hour[0] = d[5:0];
        default: ;
      endcase
    end
    @(negedge clk);
    min_tick = 0; reg_wr = 0; osc_halt = 0; now_sec = 8'h01;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    step(0, 8'h01, 8'h00, 8'h00, 3'd0, 1, a, d, 0);
  endtask

  task automatic tick(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [2:0] wd);
    step(1, s, mi, h, wd, 0, 3'd0, 8'h00, 0);
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int unsigned seed;
    m_min[0] = 0; m_min[1] = 0; m_hour[0] = 0; m_hour[1] = 0;
    seed = $urandom(32'h5eed_a1a7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1 reset read", v, 0); end
    chk("R1 irq_w_n", irq_w_n, 1); chk("R1 irq_d_n", irq_d_n, 1);

    // R2 field widths and padding
    wr(3'd0, 8'hFF); rd(3'd0, v); chk("R2 wmin pad", v, 8'h7F);
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R2 whour pad", v, 8'h3F);
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R2 mask pad", v, 8'h7F);
    wr(3'd7, 8'hFF); rd(3'd7, v); chk("R2 addr7", v, 0);

    wr(3'd0, 8'h30); wr(3'd1, 8'h12); wr(3'd2, 8'b0101010);
    wr(3'd3, 8'h45); wr(3'd4, 8'h32); wr(3'd5, 8'h03);
    rd(3'd5, v); chk("R2 ctrl", v, 3);

    // R3 weekly match on weekday 3
    tick(8'h00, 8'h30, 8'h12, 3'd3);
    chk("R3 irq_w_n", irq_w_n, 0); chk("R3 irq_d_n", irq_d_n, 1);
    rd(3'd6, v); chk("R3 status", v, 2);
    // R9 clear W by 0, D bit written 1 no effect
    wr(3'd6, 8'h01); chk("R9 release", irq_w_n, 1);
    rd(3'd6, v); chk("R9 status", v, 0);
    // R4 mask bit clear, weekday 7
    tick(8'h00, 8'h30, 8'h12, 3'd2); chk("R4 day clear", irq_w_n, 1);
    tick(8'h00, 8'h30, 8'h12, 3'd7); chk("R4 day 7", irq_w_n, 1);
    // R6 seconds nonzero, no tick
    tick(8'h01, 8'h30, 8'h12, 3'd1); chk("R6 sec", irq_w_n, 1);
    step(0, 8'h00, 8'h30, 8'h12, 3'd1, 0, 3'd0, 0, 0); chk("R6 no tick", irq_w_n, 1);
    // R13 PM bit
    tick(8'h00, 8'h45, 8'h12, 3'd7); chk("R13 hour code", irq_d_n, 1);
    // R5 daily ignores weekday
    tick(8'h00, 8'h45, 8'h32, 3'd7); chk("R5 irq_d_n", irq_d_n, 0);
    rd(3'd6, v); chk("R5 status", v, 1);
    // R8 sticky
    repeat (4) @(negedge clk);
    tick(8'h00, 8'h45, 8'h32, 3'd0); chk("R8 sticky", irq_d_n, 0);
    wr(3'd6, 8'h03); chk("R9 write one", irq_d_n, 0);
    // R10 drop enable clears
    wr(3'd5, 8'h02); chk("R10 release", irq_d_n, 1);
    rd(3'd6, v); chk("R10 status", v, 0);
    // R7 disabled
    tick(8'h00, 8'h45, 8'h32, 3'd0); chk("R7 disabled", irq_d_n, 1);
    // R12 match beats clear
    step(1, 8'h00, 8'h30, 8'h12, 3'd5, 1, 3'd6, 8'h00, 0);
    chk("R12 set wins", irq_w_n, 0);
    // R11 halt
    wr(3'd5, 8'h03); tick(8'h00, 8'h45, 8'h32, 3'd0);
    step(0, 8'h01, 0, 0, 0, 0, 0, 0, 1);
    chk("R11 irq_w_n", irq_w_n, 1); chk("R11 irq_d_n", irq_d_n, 1);
    rd(3'd5, v); chk("R11 ctrl", v, 0);
    rd(3'd6, v); chk("R11 status", v, 0);
    rd(3'd0, v); chk("R11 kept min", v, 8'h30);
    rd(3'd2, v); chk("R11 kept mask", v, 8'b0101010);

    // random phase
    wr(3'd0, 8'($urandom_range(0, 3))); wr(3'd1, 8'($urandom_range(0, 2)));
    wr(3'd2, 8'($urandom)); wr(3'd3, 8'($urandom_range(0, 3)));
    wr(3'd4, 8'($urandom_range(0, 2))); wr(3'd5, 8'h03);
    for (int i = 0; i < 400; i++) begin
      int op;
      int ch;
      op = $urandom_range(0, 9);
      ch = $urandom_range(0, 1);
      if (op < 7)
        step(1, ($urandom_range(0, 3) == 0) ? 8'h01 : 8'h00,
             {1'b0, ($urandom_range(0, 1) == 1) ? m_min[ch] : 7'($urandom_range(0, 3))},
             {2'b00, m_hour[ch]}, 3'($urandom),
             $urandom_range(0, 4) == 0, 3'd6, 8'($urandom), 0);
      else if (op < 9)
        wr(3'd6, 8'($urandom));
      else
        wr(3'd5, 8'($urandom));
      chk("R3 R5 random irq_w_n", irq_w_n, !m_flag[1]);
      chk("R5 R8 random irq_d_n", irq_d_n, !m_flag[0]);
      rd(3'd6, v); chk("R9 R12 random status", v, {6'b0, m_flag});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule